// File: doc/BRIEF.md
# Audio Frame Clock Generator

This block produces the serial audio bit clock and the left/right frame clock for an audio data port that acts as clock controller. Both clocks are divided down from the system clock. A two-bit mode code, captured at reset, selects either peripheral operation or one of three system-clock-to-sample-rate ratios: 256, 384 or 512. In every controller ratio a frame holds exactly 64 bit clocks, so the system clock is divided by 4, 6 or 8 to make the bit clock.

In peripheral operation the frame and bit clocks come from outside. The block then turns its clock output enable off, holds its own clock outputs low and raises a flag that says the clocks are external. In controller operation the block also gives a neighbouring serializer two one-cycle strobes. One marks the cycle just before each bit-clock falling edge. The other marks the cycle just before each new frame begins.

Top module: `afc_clkgen`

## Requirements
- R1: The mode code is sampled on every system clock edge while `rst_n` is low. The value present at the last such edge is kept until the next reset. Changes on `mode_sel` while out of reset have no effect on any output.
- R2: Code 00 selects peripheral operation. Out of reset, `clk_oe` is 0, `ext_clk` is 1, and `bck_o`, `lrck_o`, `bit_stb` and `frame_stb` all stay 0.
- R3: Codes 01, 10 and 11 select controller operation, with `clk_oe` 1 and `ext_clk` 0. The bit-clock period is 8 system clocks for 01 (512x), 6 for 10 (384x) and 4 for 11 (256x).
- R4: Each bit-clock period starts low and is low for its first half and high for its second half (50% duty). The first period starts at the first clock edge after reset is released.
- R5: A frame is 64 bit-clock periods. `lrck_o` is 0 during periods 0 to 31 and 1 during periods 32 to 63. It changes only at the same system clock edge at which `bck_o` falls.
- R6: `bit_stb` is 1 during exactly the last system clock cycle of every bit-clock period, which is the cycle just before `bck_o` falls, and is 0 otherwise.
- R7: `frame_stb` is 1 only in the cycle where `bit_stb` is 1 for period 63 of a frame, which is the cycle just before the next frame begins and `lrck_o` falls.
- R8: While `rst_n` is low, `bck_o`, `lrck_o`, `bit_stb` and `frame_stb` are 0, and the bit and frame counts restart from zero when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every divided clock is derived from it |
| rst_n | input | 1 | Synchronous active-low reset; the mode is captured while it is low |
| mode_sel | input | 2 | Mode code: 00 peripheral, 01 512x, 10 384x, 11 256x |
| bck_o | output | 1 | Bit clock generated in controller operation |
| lrck_o | output | 1 | Left/right frame clock generated in controller operation |
| clk_oe | output | 1 | High when the block drives the bit and frame clocks |
| ext_clk | output | 1 | High when the clocks come from outside (peripheral operation) |
| bit_stb | output | 1 | One-cycle strobe in the cycle before each bit-clock falling edge |
| frame_stb | output | 1 | One-cycle strobe in the cycle before each frame start |

## Verification
The bench changes the mode code on the last reset cycle and again at random points after release. A design that sampled the mode at the wrong edge, or kept following the pin, would show the wrong bit-clock period or a wrong output enable. Each ratio runs for two full frames and every output is compared in every cycle. This catches an off-by-one divide factor, a skewed duty cycle, a frame clock that turns at bit 31 or 33 or on a rising bit-clock edge, and strobes that sit one cycle early or late. In peripheral runs, any activity on the clock outputs or strobes is flagged. Reset is applied again before each run, so a counter that did not restart from zero shows up as a phase error in the first frame.

// File: rtl/afc_pkg.sv
// Package: shared mode encoding and ratio arithmetic for the audio frame
// clock generator. Assumes the frame length divides each supported ratio.
package afc_pkg;

    typedef enum logic [1:0] {
        MODE_PERIPH = 2'b00,
        MODE_R512   = 2'b01,
        MODE_R384   = 2'b10,
        MODE_R256   = 2'b11
    } afc_mode_e;

    localparam int RATIO_HI  = 512;
    localparam int RATIO_MID = 384;
    localparam int RATIO_LO  = 256;

    // System clocks per bit clock for a mode; 0 means no local division.
    function automatic int div_of(afc_mode_e m, int frame_bits);
        case (m)
            MODE_R512: return RATIO_HI  / frame_bits;
            MODE_R384: return RATIO_MID / frame_bits;
            MODE_R256: return RATIO_LO  / frame_bits;
            default:   return 0;
        endcase
    endfunction

endpackage

// File: rtl/afc_mode_latch.sv
// Module: afc_mode_latch
// Captures the mode code on every edge while reset is held low and keeps
// the last captured value once reset is released. Assumes the mode pins
// settle before reset ends.
module afc_mode_latch
    import afc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_in,
    output afc_mode_e  mode_q,
    output logic       ctl_en
);

    // Follow the pin during reset, freeze it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= afc_mode_e'(mode_in);
        end
    end

    // Controller operation whenever the captured code is not peripheral.
    always_comb begin
        ctl_en = (mode_q != MODE_PERIPH);
    end

endmodule

// File: rtl/afc_bit_div.sv
// Module: afc_bit_div
// Divides the system clock by an even factor to form a 50% duty bit clock.
// Each period is low for the first half and high for the second. The fall
// strobe is high in the last cycle of a period. Assumes div is even and >= 4
// whenever en is high.
module afc_bit_div #(
    parameter int DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             bck,
    output logic             fall_stb
);

    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_n;
    logic [DIV_W-1:0] half;
    logic             last;
    logic             bck_q;

    // Phase counter next state and end-of-period detect.
    always_comb begin
        half  = div >> 1;
        last  = en && (cnt_q == div - ONE);
        if (!en || last) begin
            cnt_n = '0;
        end else begin
            cnt_n = cnt_q + ONE;
        end
    end

    // Phase counter and registered clock, aligned to the same phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            bck_q <= 1'b0;
        end else begin
            cnt_q <= cnt_n;
            bck_q <= en && (cnt_n >= half);
        end
    end

    assign bck      = bck_q;
    assign fall_stb = last;

endmodule

// File: rtl/afc_frame_ctr.sv
// Module: afc_frame_ctr
// Counts bit-clock periods within a frame and forms the left/right clock:
// low in the first half of the frame and high in the second. Advances only
// on the fall strobe, so the frame clock turns with the bit clock falling.
// Assumes FRAME_BITS is an even power of two.
module afc_frame_ctr #(
    parameter int FRAME_BITS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic adv,
    output logic lrck,
    output logic frame_stb
);

    localparam int              BW   = $clog2(FRAME_BITS);
    localparam logic [BW-1:0]   LAST = BW'(FRAME_BITS - 1);
    localparam logic [BW-1:0]   HALF = BW'(FRAME_BITS / 2);
    localparam logic [BW-1:0]   ONE  = BW'(1);

    logic [BW-1:0] bit_q;
    logic [BW-1:0] bit_n;
    logic          lrck_q;

    // Next bit index within the frame.
    always_comb begin
        if (!en) begin
            bit_n = '0;
        end else if (adv) begin
            bit_n = (bit_q == LAST) ? '0 : bit_q + ONE;
        end else begin
            bit_n = bit_q;
        end
    end

    // Bit index and registered frame clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_q  <= '0;
            lrck_q <= 1'b0;
        end else begin
            bit_q  <= bit_n;
            lrck_q <= en && (bit_n >= HALF);
        end
    end

    assign lrck      = lrck_q;
    assign frame_stb = adv && (bit_q == LAST);

endmodule

// File: rtl/afc_clkgen.sv
// Module: afc_clkgen (top)
// Audio frame clock generator. Latches the mode at reset, then either
// divides the system clock into bit and frame clocks (controller) or stays
// quiet and flags external clocks (peripheral). Assumes rst_n is
// synchronous to clk and held for at least one edge.
module afc_clkgen
    import afc_pkg::*;
#(
    parameter int FRAME_BITS = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    output logic       bck_o,
    output logic       lrck_o,
    output logic       clk_oe,
    output logic       ext_clk,
    output logic       bit_stb,
    output logic       frame_stb
);

    localparam int DIV_MAX = RATIO_HI / FRAME_BITS;
    localparam int DIV_W   = $clog2(DIV_MAX + 1);

    afc_mode_e        mode_q;
    logic             ctl_en;
    logic [DIV_W-1:0] div;
    logic             fall_stb;

    afc_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (mode_sel),
        .mode_q  (mode_q),
        .ctl_en  (ctl_en)
    );

    // Divide factor chosen by the captured mode.
    always_comb begin
        div = DIV_W'(div_of(mode_q, FRAME_BITS));
    end

    afc_bit_div #(
        .DIV_W (DIV_W)
    ) u_bdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ctl_en),
        .div      (div),
        .bck      (bck_o),
        .fall_stb (fall_stb)
    );

    afc_frame_ctr #(
        .FRAME_BITS (FRAME_BITS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ctl_en),
        .adv       (fall_stb),
        .lrck      (lrck_o),
        .frame_stb (frame_stb)
    );

    assign bit_stb = fall_stb;
    assign clk_oe  = ctl_en;
    assign ext_clk = !ctl_en;

endmodule

// File: rtl/afc_clkgen_chk.sv
// Module: afc_clkgen_chk
// Port-level temporal checks for afc_clkgen, attached with bind.
module afc_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic bck_o,
    input logic lrck_o,
    input logic clk_oe,
    input logic ext_clk,
    input logic bit_stb,
    input logic frame_stb
);

    // R1
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(clk_oe) && $stable(ext_clk)));

    // R2
    periph_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_clk |-> (!clk_oe && !bck_o && !lrck_o && !bit_stb && !frame_stb));

    // R5
    lrck_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lrck_o) |-> $fell(bck_o));

    // R6
    bit_stb_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |=> $fell(bck_o));

    // R7
    frame_in_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |-> bit_stb);

    // R7
    frame_lrck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_stb |=> $fell(lrck_o));

endmodule

bind afc_clkgen afc_clkgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bck_o     (bck_o),
    .lrck_o    (lrck_o),
    .clk_oe    (clk_oe),
    .ext_clk   (ext_clk),
    .bit_stb   (bit_stb),
    .frame_stb (frame_stb)
);

// File: tb/afc_clkgen_tb.sv
// Bench for afc_clkgen: directed runs of every mode plus seeded random
// runs, with a reference model computed from the cycle count since reset.
module afc_clkgen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       bck_o, lrck_o, clk_oe, ext_clk, bit_stb, frame_stb;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    afc_clkgen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .bck_o     (bck_o),
        .lrck_o    (lrck_o),
        .clk_oe    (clk_oe),
        .ext_clk   (ext_clk),
        .bit_stb   (bit_stb),
        .frame_stb (frame_stb)
    );

    task automatic chk(string tag, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // Bit-clock period in system clocks for a mode code (R3).
    function automatic int ref_div(int m);
        case (m)
            1: return 8;
            2: return 6;
            3: return 4;
            default: return 0;
        endcase
    endfunction

    // Compare all outputs with the model, k edges after reset release.
    task automatic check_state(int m, int k);
        int  d;
        int  ph;
        int  bn;
        logic eb, el, es, ef;
        d = ref_div(m);
        if (d == 0) begin
            chk("R2 clk_oe", clk_oe, 1'b0);
            chk("R2 ext_clk", ext_clk, 1'b1);
            chk("R2 bck_o", bck_o, 1'b0);
            chk("R2 lrck_o", lrck_o, 1'b0);
            chk("R2 bit_stb", bit_stb, 1'b0);
            chk("R2 frame_stb", frame_stb, 1'b0);
        end else begin
            ph = k % d;
            bn = (k / d) % 64;
            eb = (ph >= d / 2);
            el = (bn >= 32);
            es = (ph == d - 1);
            ef = es && (bn == 63);
            if (k == 0) begin
                chk("R8 bck_o", bck_o, 1'b0);
                chk("R8 lrck_o", lrck_o, 1'b0);
            end
            chk("R1/R3 clk_oe", clk_oe, 1'b1);
            chk("R1/R3 ext_clk", ext_clk, 1'b0);
            chk("R3/R4 bck_o", bck_o, eb);
            chk("R5 lrck_o", lrck_o, el);
            chk("R6 bit_stb", bit_stb, es);
            chk("R7 frame_stb", frame_stb, ef);
        end
    endtask

    // Reset with a junk code, set the real code on the last reset edge,
    // scramble the pin after release (R1), then follow the model.
    task automatic run(int m);
        int cycles;
        rst_n    = 1'b0;
        mode_sel = 2'($urandom);
        repeat (2 + ($urandom % 4)) @(negedge clk);
        chk("R8 bit_stb in reset", bit_stb, 1'b0);
        chk("R8 frame_stb in reset", frame_stb, 1'b0);
        mode_sel = 2'(m);
        @(negedge clk);
        rst_n    = 1'b1;
        mode_sel = 2'($urandom);
        #1;
        check_state(m, 0);
        cycles = (ref_div(m) == 0) ? 200 : 128 * ref_div(m) + 20;
        for (int k = 1; k <= cycles; k++) begin
            @(posedge clk);
            #1;
            check_state(m, k);
            if ($urandom % 40 == 0) begin
                mode_sel = 2'($urandom);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        run(1);
        run(2);
        run(3);
        run(0);
        run(3);
        for (int i = 0; i < 5; i++) begin
            run(int'($urandom % 4));
        end
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule